// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital sequencer of an integrating analog-to-digital converter. The analog parts sit outside it: an integrator, a comparator that reports whether the integrator output is still above zero, and a two-way switch that feeds the integrator either the unknown input or the opposite-polarity reference. The sequencer drives the switch, runs a tick counter, and turns the comparator bit into a digital result.

A start pulse in idle begins a conversion. First the input is integrated for a fixed count of `INT_TICKS` clock cycles. Then the reference is switched in and the counter restarts from zero. The reference pulls the integrator back towards zero, and the sequencer counts the cycles until the comparator reports that zero has been reached. That count is the result, and it is proportional to the average input. A conversion therefore lasts `INT_TICKS` cycles plus the measured discharge time. If the integrator has not returned to zero after `2*INT_TICKS` reference cycles, the conversion ends with an overrange flag and a saturated result.

The states are Idle, Integrate, Deintegrate and Done. The transitions are:
- start (Idle to Integrate).
- integrate-complete (Integrate to Deintegrate).
- zero-crossing and timeout (Deintegrate to Done).
- release (Done to Idle).

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and after it is released, both switch selects, `busy_o`, `done_o`, `ovr_o` and `result_o` are 0.
- R2: A start request seen in Idle raises `sel_input_o` in the next cycle. It stays high for exactly `INT_TICKS` consecutive cycles.
- R3: When `sel_input_o` falls, `sel_ref_o` rises in the same cycle. The comparator is sampled once per reference cycle, with the reference cycles numbered from 0. If `cmp_i` is first seen low in reference cycle k, then `sel_ref_o` is high for k+1 cycles and `result_o` becomes k.
- R4: If `cmp_i` is already low in the first reference cycle, the result is 0 and the reference is applied for a single cycle.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last reference cycle. Counted from the clock edge that samples start, done is seen after `INT_TICKS` + (reference cycles) + 1 edges.
- R6: If `cmp_i` is still high in reference cycle `2*INT_TICKS`-1, the conversion times out. In that case `sel_ref_o` is high for `2*INT_TICKS` cycles, `ovr_o` becomes 1 and `result_o` becomes `2*INT_TICKS`.
- R7: `result_o` and `ovr_o` change only in the cycle that `done_o` is high. They keep their value through idle time and through the whole of the next conversion.
- R8: A start request while `busy_o` is high is ignored. It does not alter the running conversion, and it does not begin another conversion after Done.
- R9: A conversion that ends by zero-crossing clears `ovr_o` set by an earlier timeout.
- R10: `sel_input_o` and `sel_ref_o` are driven from registers and are never high together. Both are low in Idle and Done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured only in Idle |
| cmp_i | input | 1 | Comparator: 1 while the integrator output is above zero |
| sel_input_o | output | 1 | Switch to the unknown input (integrate phase) |
| sel_ref_o | output | 1 | Switch to the reference (deintegrate phase) |
| busy_o | output | 1 | High from Integrate through Done |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| ovr_o | output | 1 | Last conversion timed out |
| result_o | output | $clog2(2*INT_TICKS+1) | Measured discharge count, saturated to 2*INT_TICKS on timeout |

## Verification
A behavioural integrator in the bench adds the input level on each integrate cycle and subtracts the reference on each deintegrate cycle. This lets each test predict the result as the ceiling of `INT_TICKS*vin/vref`.

The input levels are chosen to probe distinct paths:
- A zero input exercises the immediate zero-crossing.
- Mid-scale levels, including ones that do not divide evenly by the reference, separate off-by-one errors in counter restart and comparator sampling.
- The largest in-range level sits one count below the timeout and separates it from the smallest overrange level.

Start pulses injected during Integrate and Deintegrate show that requests are ignored while busy. Reading the result in the middle of the following conversion shows that the result is held.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INTEG = 2'd1,
        PH_DEINT = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;
endpackage

// File: rtl/dsadc_tick_ctr.sv
module dsadc_tick_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (en_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int INT_TICKS = 16,
    parameter int W         = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    input  logic [W-1:0] cnt_i,
    output logic         ctr_clr_o,
    output logic         ctr_en_o,
    output logic         cap_o,
    output logic         cap_ovr_o,
    output logic         sel_input_o,
    output logic         sel_ref_o,
    output logic         busy_o,
    output logic         done_o
);
    localparam logic [W-1:0] INT_LAST   = W'(INT_TICKS - 1);
    localparam logic [W-1:0] DEINT_LAST = W'(2 * INT_TICKS - 1);

    phase_t ph, ph_nxt;

    always_comb begin
        ph_nxt    = ph;
        ctr_clr_o = 1'b0;
        ctr_en_o  = 1'b0;
        cap_o     = 1'b0;
        cap_ovr_o = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                if (start_i) begin
                    ph_nxt    = PH_INTEG;
                    ctr_clr_o = 1'b1;
                end
            end
            PH_INTEG: begin
                if (cnt_i == INT_LAST) begin
                    ph_nxt    = PH_DEINT;
                    ctr_clr_o = 1'b1;
                end else begin
                    ctr_en_o = 1'b1;
                end
            end
            PH_DEINT: begin
                if (!cmp_i) begin
                    ph_nxt = PH_DONE;
                    cap_o  = 1'b1;
                end else if (cnt_i == DEINT_LAST) begin
                    ph_nxt    = PH_DONE;
                    cap_o     = 1'b1;
                    cap_ovr_o = 1'b1;
                end else begin
                    ctr_en_o = 1'b1;
                end
            end
            PH_DONE: begin
                ph_nxt = PH_IDLE;
            end
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nxt;
    end

    // registered outputs, decoded from the next phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_input_o <= 1'b0;
            sel_ref_o   <= 1'b0;
            busy_o      <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            sel_input_o <= (ph_nxt == PH_INTEG);
            sel_ref_o   <= (ph_nxt == PH_DEINT);
            busy_o      <= (ph_nxt != PH_IDLE);
            done_o      <= (ph_nxt == PH_DONE);
        end
    end

    // R10
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_input_o, sel_ref_o}));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    phase_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_input_o) |-> sel_ref_o);

    // R5
    ref_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_ref_o) |-> done_o);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !$rose(sel_input_o));
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
    parameter int INT_TICKS = 16,
    parameter int W         = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic         cap_ovr_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] result_o,
    output logic         ovr_o
);
    localparam logic [W-1:0] SAT = W'(2 * INT_TICKS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
        end else if (cap_i) begin
            result_o <= cap_ovr_i ? SAT : cnt_i;
            ovr_o    <= cap_ovr_i;
        end
    end

    // R6
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> (result_o == SAT));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(result_o) && $stable(ovr_o)));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
    parameter int INT_TICKS = 16,
    localparam int RES_W    = $clog2(2 * INT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             sel_input_o,
    output logic             sel_ref_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ovr_o,
    output logic [RES_W-1:0] result_o
);
    logic             ctr_clr, ctr_en, cap, cap_ovr;
    logic [RES_W-1:0] cnt;

    dsadc_tick_ctr #(.W(RES_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ctr_clr),
        .en_i  (ctr_en),
        .cnt_o (cnt)
    );

    dsadc_fsm #(.INT_TICKS(INT_TICKS), .W(RES_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_i       (cmp_i),
        .cnt_i       (cnt),
        .ctr_clr_o   (ctr_clr),
        .ctr_en_o    (ctr_en),
        .cap_o       (cap),
        .cap_ovr_o   (cap_ovr),
        .sel_input_o (sel_input_o),
        .sel_ref_o   (sel_ref_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    dsadc_result_reg #(.INT_TICKS(INT_TICKS), .W(RES_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap),
        .cap_ovr_i (cap_ovr),
        .cnt_i     (cnt),
        .result_o  (result_o),
        .ovr_o     (ovr_o)
    );

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> sel_input_o);
endmodule

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
    localparam int N     = 16;
    localparam int RES_W = $clog2(2 * N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             cmp_i;
    logic             sel_input_o, sel_ref_o, busy_o, done_o, ovr_o;
    logic [RES_W-1:0] result_o;

    int errors = 0;
    int checks = 0;
    int vin = 0;
    int vref = 16;
    int acc = 0;
    int prev_res = 0;
    int prev_ovr = 0;

    always #5 clk = ~clk;

    dual_slope_seq #(.INT_TICKS(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_i       (cmp_i),
        .sel_input_o (sel_input_o),
        .sel_ref_o   (sel_ref_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ovr_o       (ovr_o),
        .result_o    (result_o)
    );

    // behavioural integrator
    always @(posedge clk) begin
        if (!rst_n || !busy_o)  acc <= 0;
        else if (sel_input_o)   acc <= acc + vin;
        else if (sel_ref_o)     acc <= acc - vref;
    end
    assign cmp_i = (acc > 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!sel_input_o && !sel_ref_o && !busy_o && !done_o, "R1 outputs in reset",
              {sel_input_o, sel_ref_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(result_o == 0 && !ovr_o, "R1 result after reset", int'(result_o), 0);
        check(!sel_input_o && !sel_ref_o && !busy_o, "R1 idle after reset",
              {sel_input_o, sel_ref_o, busy_o}, 0);
    endtask

    // one conversion; start held high during cycles [inj_lo, inj_hi] (0 = none)
    task automatic t_conv(input int v, input int r, input int inj_lo, input int inj_hi,
                          input string tag);
        int k, exp_res, exp_ref, exp_ovr, n_in, n_ref, cnt;
        bit hold_ok;
        k       = (N * v + r - 1) / r;
        exp_ovr = (k >= 2 * N) ? 1 : 0;
        exp_res = exp_ovr ? 2 * N : k;
        exp_ref = exp_ovr ? 2 * N : k + 1;
        @(negedge clk);
        vin = v; vref = r;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        cnt = 1; n_in = 0; n_ref = 0; hold_ok = 1'b1;
        while (!done_o && cnt < 1000) begin
            n_in  += int'(sel_input_o);
            n_ref += int'(sel_ref_o);
            if (int'(result_o) != prev_res || int'(ovr_o) != prev_ovr) hold_ok = 1'b0;
            start_i = (inj_lo != 0 && cnt >= inj_lo && cnt <= inj_hi);
            @(posedge clk); #1;
            cnt++;
        end
        start_i = 1'b0;
        $display("%s: vin=%0d vref=%0d result=%0d ovr=%0d", tag, v, r, result_o, ovr_o);
        check(hold_ok, "R7 result held during conversion", int'(hold_ok), 1);
        check(n_in == N, "R2 integrate length", n_in, N);
        check(n_ref == exp_ref, exp_ovr ? "R6 reference length" : "R3 reference length",
              n_ref, exp_ref);
        check(cnt == N + exp_ref + 1, "R5 start-to-done latency", cnt, N + exp_ref + 1);
        check(int'(result_o) == exp_res, exp_ovr ? "R6 saturated result" : "R3 result",
              int'(result_o), exp_res);
        check(int'(ovr_o) == exp_ovr, exp_ovr ? "R6 overrange flag" : "R9 overrange clear",
              int'(ovr_o), exp_ovr);
        prev_res = exp_res;
        prev_ovr = exp_ovr;
        @(posedge clk); #1;
        check(!done_o, "R5 done single cycle", int'(done_o), 0);
        repeat (4) @(posedge clk);
        #1;
        check(!busy_o && !sel_input_o && !sel_ref_o, "R8 no restart after done",
              {busy_o, sel_input_o, sel_ref_o}, 0);
        check(int'(result_o) == exp_res && int'(ovr_o) == exp_ovr, "R7 result held in idle",
              int'(result_o), exp_res);
    endtask

    task automatic t_zero();
        t_conv(0, 16, 0, 0, "R4 zero input");
        check(result_o == 0, "R4 zero result", int'(result_o), 0);
    endtask

    task automatic t_overrange();
        t_conv(32, 16, 0, 0, "R6 smallest overrange");
        t_conv(7, 16, 0, 0, "R9 recover after overrange");
    endtask

    task automatic t_busy_start();
        t_conv(10, 16, 3, 6, "R8 start during integrate");
        t_conv(12, 16, N + 3, N + 5, "R8 start during deintegrate");
    endtask

    initial begin : watchdog
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_zero();
        t_conv(8, 16, 0, 0, "R3 mid-scale");
        t_conv(3, 10, 0, 0, "R3 uneven ratio");
        t_conv(1, 16, 0, 0, "R3 one count");
        t_conv(31, 16, 0, 0, "R3 largest in range");
        t_overrange();
        t_busy_start();
        // R10 selects low after all tests
        check(!sel_input_o && !sel_ref_o, "R10 selects low in idle",
              {sel_input_o, sel_ref_o}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule